// File: doc/BRIEF.md
# DMA copy engine register front end

This block is the memory-mapped register interface of a descriptor-driven DMA copy engine. It covers the global registers and one channel. A host-side register bus issues single accesses, each with an offset, a size code and, for writes, data. The block decodes each access and updates its registers. It returns the read value, or an error flag, in the following cycle.

Several reads have side effects: reading the interrupt control register drops the master enable, reading the channel control register marks the channel in use, and reading the attention register empties it. The descriptor chain address and the completion address are 64-bit registers. They can be written whole, or as two 32-bit halves, and each half write keeps the other half. The channel error register is cleared by writing ones to it. A write to the command register stores the command and sends a one-cycle strobe to the transfer engine. That engine returns a busy flag, a raw status word, error-set pulses and attention-set pulses.

Top module: `dmace_regs`

## Requirements
- R1: A byte read at offset 0x00 returns the CHAN_COUNT parameter, and a byte read at offset 0x01 returns the XFER_CAP parameter. A write to either offset is an error.
- R2: A byte access at offset 0x03 is interrupt control, and its bit 0 is the master enable, shown on int_en_o. A write loads the enable from wdata_i[0]. A read returns the enable in bit 0, with zeros above it, and then clears the enable.
- R3: A word read at offset 0x04 returns the attention bits and then clears them. Each attn_set_i bit sets its attention bit, which stays set until such a read. A set that arrives in the same cycle as the read survives the read. Any write to this offset is an error.
- R4: A halfword access at offset 0x80 is channel control, shown on ctrl_o. A write stores wdata_i[15:0]. A read returns the stored value and then sets bit INUSE_BIT (default 8).
- R5: A doubleword read at offset 0x90 returns status_i, with bit 0 forced to 1 when busy_i is low and passed through unchanged when busy_i is high. Any write to this offset is an error.
- R6: Offsets 0x98 (chain address) and 0xA0 (completion address) accept word and doubleword accesses. A doubleword write replaces all 64 bits. A word write replaces bits 31:0 and keeps bits 63:32. A doubleword read returns all 64 bits, and a word read returns bits 31:0.
- R7: Offsets 0x9C and 0xA4 take word accesses only, to bits 63:32 of the chain and completion address respectively. A write replaces bits 63:32 and keeps bits 31:0. A read returns bits 63:32.
- R8: A byte write at offset 0x84 stores wdata_i[7:0] on cmd_o. It raises cmd_stb_o for exactly the one cycle after the write edge. A byte read at this offset returns the stored command and raises no strobe.
- R9: A word access at offset 0x88 is the channel error register. Each err_set_i bit sets its error bit. A write clears every bit where wdata_i has a 1. If a bit is set and cleared in the same cycle, the set wins. A read returns the register.
- R10: An access is an error if its size is not allowed at its offset, if its offset is unknown, or if it writes a read-only register. An error access raises err_o in the next cycle, returns zero on rdata_o, changes no register and raises no strobe.
- R11: size_i codes the access width: 0 is byte, 1 is halfword, 2 is word, 3 is doubleword. rdata_o and err_o are registered, so they are valid in the cycle after the access edge. Read data is little-endian and right-aligned: byte k of the register is on bits 8k+7:8k, and all bits above the access width are zero. A write access returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register byte offset |
| size_i | input | 2 | Access size code |
| wdata_i | input | 64 | Write data, right-aligned |
| rdata_o | output | 64 | Read data of the previous access |
| err_o | output | 1 | Previous access was rejected |
| busy_i | input | 1 | Transfer engine busy |
| status_i | input | 64 | Raw channel status from the engine |
| err_set_i | input | 32 | Channel error set pulses |
| attn_set_i | input | 32 | Attention set pulses |
| int_en_o | output | 1 | Master interrupt enable |
| ctrl_o | output | 16 | Channel control value |
| cmd_o | output | 8 | Last command written |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| chain_addr_o | output | 64 | Descriptor chain address |
| cmpl_addr_o | output | 64 | Completion address |

## Verification
The bench uses the default parameters. With ADDR_W of 8, the whole offset space is 256 offsets by 4 size codes, small enough to sweep completely. Every read combination is swept and its error flag compared with a legality rule worked out in the bench. Every illegal write is then swept with all-ones data, and afterwards every register is read back unchanged. Directed sequences cover the read side effects, the merges of the 32-bit halves, write-one-to-clear, and same-cycle races between set and clear.

// File: rtl/dmace_pkg.sv
`timescale 1ns/1ps
package dmace_pkg;
  localparam int DW     = 64;
  localparam int HW     = 32;
  localparam int CTRL_W = 16;
  localparam int CMD_W  = 8;
  localparam int ERR_W  = 32;
  localparam int ATTN_W = 32;

  localparam int OFS_CCOUNT   = 'h00;
  localparam int OFS_XCAP     = 'h01;
  localparam int OFS_INTC     = 'h03;
  localparam int OFS_ATTN     = 'h04;
  localparam int OFS_CTRL     = 'h80;
  localparam int OFS_CMD      = 'h84;
  localparam int OFS_ERR      = 'h88;
  localparam int OFS_STAT     = 'h90;
  localparam int OFS_CHAIN_LO = 'h98;
  localparam int OFS_CHAIN_HI = 'h9C;
  localparam int OFS_CMPL_LO  = 'hA0;
  localparam int OFS_CMPL_HI  = 'hA4;

  typedef enum logic [1:0] {
    SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CCOUNT, SEL_XCAP, SEL_INTC, SEL_ATTN, SEL_CTRL, SEL_CMD,
    SEL_ERR, SEL_STAT, SEL_CHAIN_LO, SEL_CHAIN_HI, SEL_CMPL_LO, SEL_CMPL_HI
  } reg_sel_e;
endpackage

// File: rtl/dmace_decode.sv
`timescale 1ns/1ps
module dmace_decode
  import dmace_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              ok_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFS_CCOUNT))   sel_o = SEL_CCOUNT;
    else if (addr_i == ADDR_W'(OFS_XCAP))     sel_o = SEL_XCAP;
    else if (addr_i == ADDR_W'(OFS_INTC))     sel_o = SEL_INTC;
    else if (addr_i == ADDR_W'(OFS_ATTN))     sel_o = SEL_ATTN;
    else if (addr_i == ADDR_W'(OFS_CTRL))     sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_CMD))      sel_o = SEL_CMD;
    else if (addr_i == ADDR_W'(OFS_ERR))      sel_o = SEL_ERR;
    else if (addr_i == ADDR_W'(OFS_STAT))     sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_CHAIN_LO)) sel_o = SEL_CHAIN_LO;
    else if (addr_i == ADDR_W'(OFS_CHAIN_HI)) sel_o = SEL_CHAIN_HI;
    else if (addr_i == ADDR_W'(OFS_CMPL_LO))  sel_o = SEL_CMPL_LO;
    else if (addr_i == ADDR_W'(OFS_CMPL_HI))  sel_o = SEL_CMPL_HI;
  end

  always_comb begin
    unique case (sel_o)
      SEL_CCOUNT, SEL_XCAP:        ok_o = (size_i == SZ_B) && !we_i;
      SEL_INTC, SEL_CMD:           ok_o = (size_i == SZ_B);
      SEL_ATTN:                    ok_o = (size_i == SZ_W) && !we_i;
      SEL_CTRL:                    ok_o = (size_i == SZ_H);
      SEL_ERR:                     ok_o = (size_i == SZ_W);
      SEL_STAT:                    ok_o = (size_i == SZ_D) && !we_i;
      SEL_CHAIN_LO, SEL_CMPL_LO:   ok_o = (size_i == SZ_W) || (size_i == SZ_D);
      SEL_CHAIN_HI, SEL_CMPL_HI:   ok_o = (size_i == SZ_W);
      default:                     ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmace_glob_regs.sv
`timescale 1ns/1ps
module dmace_glob_regs
  import dmace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              intc_wr_i,
  input  logic              intc_rd_i,
  input  logic              en_bit_i,
  input  logic              attn_rd_i,
  input  logic [ATTN_W-1:0] attn_set_i,
  output logic              mie_o,
  output logic [ATTN_W-1:0] attn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_o  <= 1'b0;
      attn_o <= '0;
    end else begin
      if (intc_wr_i)      mie_o <= en_bit_i;
      else if (intc_rd_i) mie_o <= 1'b0;
      // new sets survive a clearing read
      attn_o <= (attn_rd_i ? '0 : attn_o) | attn_set_i;
    end
  end
endmodule

// File: rtl/dmace_addr64.sv
`timescale 1ns/1ps
module dmace_addr64
  import dmace_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic          wide_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_o <= '0;
    else if (lo_wr_i && wide_i)  addr_o <= wdata_i;
    else if (lo_wr_i)            addr_o <= {addr_o[DW-1:HW], wdata_i[HW-1:0]};
    else if (hi_wr_i)            addr_o <= {wdata_i[HW-1:0], addr_o[HW-1:0]};
  end
endmodule

// File: rtl/dmace_chan_regs.sv
`timescale 1ns/1ps
module dmace_chan_regs
  import dmace_pkg::*;
#(
  parameter int INUSE_BIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_rd_i,
  input  logic             cmd_wr_i,
  input  logic             err_wr_i,
  input  logic [1:0]       lo_wr_i,
  input  logic [1:0]       hi_wr_i,
  input  logic             wide_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [ERR_W-1:0] err_set_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_stb_o,
  output logic [DW-1:0]    chain_o,
  output logic [DW-1:0]    cmpl_o,
  output logic [ERR_W-1:0] err_o
);
  logic [1:0][DW-1:0] addr_q;

  // index 0: chain address, index 1: completion address
  for (genvar g = 0; g < 2; g++) begin : g_addr
    dmace_addr64 u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_wr_i (lo_wr_i[g]),
      .hi_wr_i (hi_wr_i[g]),
      .wide_i  (wide_i),
      .wdata_i (wdata_i),
      .addr_o  (addr_q[g])
    );
  end
  assign chain_o = addr_q[0];
  assign cmpl_o  = addr_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      cmd_o     <= '0;
      cmd_stb_o <= 1'b0;
      err_o     <= '0;
    end else begin
      if (ctrl_wr_i)      ctrl_o <= wdata_i[CTRL_W-1:0];
      else if (ctrl_rd_i) ctrl_o[INUSE_BIT] <= 1'b1;
      if (cmd_wr_i) cmd_o <= wdata_i[CMD_W-1:0];
      cmd_stb_o <= cmd_wr_i;
      // set wins over a same-cycle clear
      err_o <= (err_o & ~(err_wr_i ? wdata_i[ERR_W-1:0] : '0)) | err_set_i;
    end
  end
endmodule

// File: rtl/dmace_regs.sv
`timescale 1ns/1ps
module dmace_regs
  import dmace_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] CHAN_COUNT = 8'd1,
  parameter logic [7:0] XFER_CAP   = 8'd12,
  parameter int         INUSE_BIT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              err_o,
  input  logic              busy_i,
  input  logic [63:0]       status_i,
  input  logic [31:0]       err_set_i,
  input  logic [31:0]       attn_set_i,
  output logic              int_en_o,
  output logic [15:0]       ctrl_o,
  output logic [7:0]        cmd_o,
  output logic              cmd_stb_o,
  output logic [63:0]       chain_addr_o,
  output logic [63:0]       cmpl_addr_o
);
  reg_sel_e          sel;
  logic              ok;
  logic              acc, rd, wr;
  logic              wide;
  logic [ATTN_W-1:0] attn_q;
  logic [ERR_W-1:0]  cerr_q;
  logic [DW-1:0]     rd_val;

  dmace_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .we_i   (we_i),
    .sel_o  (sel),
    .ok_o   (ok)
  );

  assign acc  = req_i && ok;
  assign rd   = acc && !we_i;
  assign wr   = acc && we_i;
  assign wide = (size_i == SZ_D);

  dmace_glob_regs u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .intc_wr_i  (wr && sel == SEL_INTC),
    .intc_rd_i  (rd && sel == SEL_INTC),
    .en_bit_i   (wdata_i[0]),
    .attn_rd_i  (rd && sel == SEL_ATTN),
    .attn_set_i (attn_set_i),
    .mie_o      (int_en_o),
    .attn_o     (attn_q)
  );

  dmace_chan_regs #(.INUSE_BIT(INUSE_BIT)) u_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr && sel == SEL_CTRL),
    .ctrl_rd_i (rd && sel == SEL_CTRL),
    .cmd_wr_i  (wr && sel == SEL_CMD),
    .err_wr_i  (wr && sel == SEL_ERR),
    .lo_wr_i   ({wr && sel == SEL_CMPL_LO, wr && sel == SEL_CHAIN_LO}),
    .hi_wr_i   ({wr && sel == SEL_CMPL_HI, wr && sel == SEL_CHAIN_HI}),
    .wide_i    (wide),
    .wdata_i   (wdata_i),
    .err_set_i (err_set_i),
    .ctrl_o    (ctrl_o),
    .cmd_o     (cmd_o),
    .cmd_stb_o (cmd_stb_o),
    .chain_o   (chain_addr_o),
    .cmpl_o    (cmpl_addr_o),
    .err_o     (cerr_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CCOUNT:   rd_val = DW'(CHAN_COUNT);
      SEL_XCAP:     rd_val = DW'(XFER_CAP);
      SEL_INTC:     rd_val = DW'(int_en_o);
      SEL_ATTN:     rd_val = DW'(attn_q);
      SEL_CTRL:     rd_val = DW'(ctrl_o);
      SEL_CMD:      rd_val = DW'(cmd_o);
      SEL_ERR:      rd_val = DW'(cerr_q);
      SEL_STAT:     rd_val = status_i | DW'(!busy_i);
      SEL_CHAIN_LO: rd_val = wide ? chain_addr_o : DW'(chain_addr_o[HW-1:0]);
      SEL_CHAIN_HI: rd_val = DW'(chain_addr_o[DW-1:HW]);
      SEL_CMPL_LO:  rd_val = wide ? cmpl_addr_o : DW'(cmpl_addr_o[HW-1:0]);
      SEL_CMPL_HI:  rd_val = DW'(cmpl_addr_o[DW-1:HW]);
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= req_i && !ok;
      if (req_i) rdata_o <= rd ? rd_val : '0;
    end
  end
endmodule

// File: rtl/dmace_regs_chk.sv
`timescale 1ns/1ps
module dmace_regs_chk
  import dmace_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INUSE_BIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [63:0]       wdata_i,
  input logic [31:0]       err_set_i,
  input logic [31:0]       attn_set_i,
  input logic              err_o,
  input logic              int_en_o,
  input logic [15:0]       ctrl_o,
  input logic [7:0]        cmd_o,
  input logic              cmd_stb_o,
  input logic [63:0]       chain_addr_o,
  input logic [63:0]       cmpl_addr_o,
  input logic [31:0]       attn_q,
  input logic [31:0]       cerr_q
);
  logic at_intc_rd, at_ctrl_rd, at_cmd_wr, at_chain_hi_wr, at_attn_rd, at_err_wr;
  assign at_intc_rd     = req_i && !we_i && addr_i == ADDR_W'(OFS_INTC) && size_i == 2'd0;
  assign at_ctrl_rd     = req_i && !we_i && addr_i == ADDR_W'(OFS_CTRL) && size_i == 2'd1;
  assign at_cmd_wr      = req_i && we_i && addr_i == ADDR_W'(OFS_CMD) && size_i == 2'd0;
  assign at_chain_hi_wr = req_i && we_i && addr_i == ADDR_W'(OFS_CHAIN_HI) && size_i == 2'd2;
  assign at_attn_rd     = req_i && !we_i && addr_i == ADDR_W'(OFS_ATTN) && size_i == 2'd2;
  assign at_err_wr      = req_i && we_i && addr_i == ADDR_W'(OFS_ERR) && size_i == 2'd2;

  // R2
  intc_rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_intc_rd |=> !int_en_o);
  // R4
  ctrl_inuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_ctrl_rd |=> ctrl_o == ($past(ctrl_o) | (16'd1 << INUSE_BIT)));
  // R8
  cmd_stb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> $past(at_cmd_wr));
  // R8
  cmd_stb_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_cmd_wr |=> cmd_stb_o && cmd_o == $past(wdata_i[7:0]));
  // R7
  chain_hi_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_chain_hi_wr |=> chain_addr_o == {$past(wdata_i[31:0]), $past(chain_addr_o[31:0])});
  // R3
  attn_rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_attn_rd && attn_set_i == 32'd0 |=> attn_q == 32'd0);
  // R9
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_err_wr |=> cerr_q == (($past(cerr_q) & ~$past(wdata_i[31:0])) | $past(err_set_i)));
  // R10
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(chain_addr_o) && $stable(cmpl_addr_o) && $stable(ctrl_o)
              && $stable(cmd_o) && $stable(int_en_o) && !cmd_stb_o);
endmodule

bind dmace_regs dmace_regs_chk #(.ADDR_W(ADDR_W), .INUSE_BIT(INUSE_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .size_i       (size_i),
  .wdata_i      (wdata_i),
  .err_set_i    (err_set_i),
  .attn_set_i   (attn_set_i),
  .err_o        (err_o),
  .int_en_o     (int_en_o),
  .ctrl_o       (ctrl_o),
  .cmd_o        (cmd_o),
  .cmd_stb_o    (cmd_stb_o),
  .chain_addr_o (chain_addr_o),
  .cmpl_addr_o  (cmpl_addr_o),
  .attn_q       (attn_q),
  .cerr_q       (cerr_q)
);

// File: tb/dmace_regs_test.sv
`timescale 1ns/1ps
module dmace_regs_test;
  localparam logic [7:0] CC = 8'd1;
  localparam logic [7:0] XC = 8'd12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        err_o;
  logic        busy_i = 1'b0;
  logic [63:0] status_i = '0;
  logic [31:0] err_set_i = '0, attn_set_i = '0;
  logic        int_en_o;
  logic [15:0] ctrl_o;
  logic [7:0]  cmd_o;
  logic        cmd_stb_o;
  logic [63:0] chain_addr_o, cmpl_addr_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  dmace_regs #(.ADDR_W(8), .CHAN_COUNT(CC), .XFER_CAP(XC), .INUSE_BIT(8)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .busy_i(busy_i), .status_i(status_i), .err_set_i(err_set_i),
    .attn_set_i(attn_set_i), .int_en_o(int_en_o), .ctrl_o(ctrl_o), .cmd_o(cmd_o),
    .cmd_stb_o(cmd_stb_o), .chain_addr_o(chain_addr_o), .cmpl_addr_o(cmpl_addr_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; returns at the negedge where its response is visible
  task automatic acc(input bit w, input logic [7:0] a, input logic [1:0] s, input logic [63:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; size_i = s; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  function automatic bit legal(input int a, input int s, input bit w);
    case (a)
      'h00, 'h01: return s == 0 && !w;
      'h03, 'h84: return s == 0;
      'h04:       return s == 2 && !w;
      'h80:       return s == 1;
      'h88, 'h9C, 'hA4: return s == 2;
      'h90:       return s == 3 && !w;
      'h98, 'hA0: return s == 2 || s == 3;
      default:    return 0;
    endcase
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  logic [63:0] snap_chain, snap_cmpl;
  logic [15:0] snap_ctrl;
  logic [7:0]  snap_cmd;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk("R11 reset rdata", rdata_o, 0);
    chk("R10 reset err", err_o, 0);
    chk("R2 reset int_en", int_en_o, 0);
    chk("R4 reset ctrl", ctrl_o, 0);
    chk("R8 reset stb", cmd_stb_o, 0);
    chk("R6 reset chain", chain_addr_o, 0);
    chk("R6 reset cmpl", cmpl_addr_o, 0);

    // R1
    acc(0, 8'h00, 0, 0); chk("R1 chan count", rdata_o, CC); chk("R1 err", err_o, 0);
    acc(0, 8'h01, 0, 0); chk("R1 xfer cap", rdata_o, XC);
    acc(1, 8'h01, 0, 8'hFF); chk("R1 write rejected", err_o, 1);
    acc(0, 8'h01, 0, 0); chk("R1 xfer cap kept", rdata_o, XC);

    // R2
    acc(1, 8'h03, 0, 64'hFF); chk("R2 enable set", int_en_o, 1); chk("R11 write data zero", rdata_o, 0);
    acc(0, 8'h03, 0, 0); chk("R2 read value", rdata_o, 1); chk("R2 cleared by read", int_en_o, 0);
    acc(0, 8'h03, 0, 0); chk("R2 second read", rdata_o, 0);
    acc(1, 8'h03, 0, 64'h01); acc(1, 8'h03, 0, 64'hFE); chk("R2 load bit0 zero", int_en_o, 0);

    // R3
    attn_set_i = 32'h5; @(negedge clk_i); attn_set_i = 32'h100; @(negedge clk_i); attn_set_i = 0;
    acc(0, 8'h04, 2, 0); chk("R3 sticky read", rdata_o, 64'h105);
    acc(0, 8'h04, 2, 0); chk("R3 cleared", rdata_o, 0);
    attn_set_i = 32'h8; acc(0, 8'h04, 2, 0); attn_set_i = 0;
    chk("R3 race read", rdata_o, 0);
    acc(0, 8'h04, 2, 0); chk("R3 race set survives", rdata_o, 64'h8);

    // R4, R11 byte order
    acc(1, 8'h80, 1, 64'hFFFF_0000_0000_1234); chk("R4 ctrl stored", ctrl_o, 16'h1234);
    acc(0, 8'h80, 1, 0); chk("R4 read value", rdata_o, 64'h1234);
    chk("R11 low byte", rdata_o[7:0], 8'h34);
    chk("R4 in-use set", ctrl_o, 16'h1334);
    acc(0, 8'h80, 1, 0); chk("R4 read after in-use", rdata_o, 64'h1334);

    // R5
    status_i = 64'hA5A5_0000_1234_5670; busy_i = 0;
    acc(0, 8'h90, 3, 0); chk("R5 idle forces bit0", rdata_o, 64'hA5A5_0000_1234_5671);
    busy_i = 1; acc(0, 8'h90, 3, 0); chk("R5 busy passes", rdata_o, 64'hA5A5_0000_1234_5670);
    status_i = 64'h3; acc(0, 8'h90, 3, 0); chk("R5 busy bit0 from status", rdata_o, 64'h3);
    busy_i = 0;

    // R6, R7 on both addresses
    for (int i = 0; i < 2; i++) begin
      logic [7:0] lo;
      lo = (i == 0) ? 8'h98 : 8'hA0;
      acc(1, lo, 3, 64'h1111_2222_3333_4444);
      chk("R6 full write", i ? cmpl_addr_o : chain_addr_o, 64'h1111_2222_3333_4444);
      acc(1, lo, 2, 64'hFFFF_FFFF_AAAA_BBBB);
      chk("R6 low merge", i ? cmpl_addr_o : chain_addr_o, 64'h1111_2222_AAAA_BBBB);
      acc(1, lo + 8'd4, 2, 64'h9999_9999_CCCC_DDDD);
      chk("R7 high merge", i ? cmpl_addr_o : chain_addr_o, 64'hCCCC_DDDD_AAAA_BBBB);
      acc(0, lo + 8'd4, 2, 0); chk("R7 high read", rdata_o, 64'hCCCC_DDDD);
      acc(0, lo, 2, 0); chk("R6 low word read", rdata_o, 64'hAAAA_BBBB);
      acc(0, lo, 3, 0); chk("R6 full read", rdata_o, 64'hCCCC_DDDD_AAAA_BBBB);
    end
    chk("R6 chain untouched by cmpl", chain_addr_o, 64'hCCCC_DDDD_AAAA_BBBB);

    // R8
    acc(1, 8'h84, 0, 64'h5A);
    chk("R8 strobe high", cmd_stb_o, 1); chk("R8 command", cmd_o, 8'h5A);
    @(negedge clk_i); chk("R8 strobe one cycle", cmd_stb_o, 0);
    acc(0, 8'h84, 0, 0); chk("R8 read command", rdata_o, 64'h5A); chk("R8 read no strobe", cmd_stb_o, 0);

    // R9
    err_set_i = 32'hF0F0; @(negedge clk_i); err_set_i = 0;
    acc(0, 8'h88, 2, 0); chk("R9 set", rdata_o, 64'hF0F0);
    acc(1, 8'h88, 2, 64'h00F0); acc(0, 8'h88, 2, 0); chk("R9 w1c", rdata_o, 64'hF000);
    err_set_i = 32'h1; acc(1, 8'h88, 2, 64'h1); err_set_i = 0;
    acc(0, 8'h88, 2, 0); chk("R9 set wins", rdata_o, 64'hF001);
    acc(1, 8'h88, 2, 64'hFFFF_FFFF); acc(0, 8'h88, 2, 0); chk("R9 clear all", rdata_o, 0);

    // R10 read sweep over the whole offset space
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++) begin
        acc(0, 8'(a), 2'(s), 0);
        chk("R10 read legality", err_o, !legal(a, s, 0));
        if (!legal(a, s, 0)) chk("R10 error data zero", rdata_o, 0);
      end

    // R10 illegal write sweep, then read back every register
    acc(1, 8'h03, 0, 64'h1);
    err_set_i = 32'h55; @(negedge clk_i); err_set_i = 0;
    acc(0, 8'h04, 2, 0);
    snap_chain = chain_addr_o; snap_cmpl = cmpl_addr_o; snap_ctrl = ctrl_o; snap_cmd = cmd_o;
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++)
        if (!legal(a, s, 1)) begin
          acc(1, 8'(a), 2'(s), '1);
          chk("R10 write rejected", err_o, 1);
          chk("R10 no strobe", cmd_stb_o, 0);
        end
    chk("R10 chain kept", chain_addr_o, snap_chain);
    chk("R10 cmpl kept", cmpl_addr_o, snap_cmpl);
    chk("R10 ctrl kept", ctrl_o, snap_ctrl);
    chk("R10 cmd kept", cmd_o, snap_cmd);
    chk("R10 enable kept", int_en_o, 1);
    acc(0, 8'h88, 2, 0); chk("R10 error reg kept", rdata_o, 64'h55);
    acc(0, 8'h04, 2, 0); chk("R10 attention kept", rdata_o, 0);
    acc(0, 8'h00, 0, 0); chk("R10 chan count kept", rdata_o, CC);
    chk("R11 legal err low", err_o, 0);

    finish_run();
  end
endmodule